// File: doc/BRIEF.md
# Timer PWM Output Stage

This block turns the state of an up/down timer into a single pulse-width-modulated output pin. It watches the running counter value and a one-cycle timeout strobe from the timer, and compares the counter against a programmable match value. The waveform comes from one of two modes. In toggle mode the pin flips level on every timeout. In match mode the pin becomes active when the counter reaches the match value and goes back to idle at the next timeout.

The idle level is programmable, and "active" always means the inverse of that level. A match that lands in the same cycle as a timeout, or a match value the counter never reaches, leaves the pin idle. Any change of the mode or idle-level selection puts the pin back to idle. The block runs on the timer clock with a synchronous active-low reset. The counter itself, register decoding and clock-domain crossing are handled elsewhere.

Top module: `pwm_match_out`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pwm_out` is 0. The internal copies of the mode and idle selections reset to 0 (toggle mode, idle low).
- R2: `idle_high` = 0 makes the idle level 0 and `idle_high` = 1 makes it 1. The active level is always the inverse of the idle level.
- R3: `mode_match` = 0 selects toggle mode and `mode_match` = 1 selects match mode.
- R4: In match mode, when `cnt_value` equals `match_val` and `timeout` is low in some cycle, `pwm_out` is at the active level from the next cycle.
- R5: In match mode, a `timeout` pulse returns `pwm_out` to the idle level on the next cycle.
- R6: In match mode, a match and a `timeout` in the same cycle leave `pwm_out` at the idle level.
- R7: In match mode, if the counter never equals `match_val`, `pwm_out` stays at the idle level across any number of timeouts.
- R8: In toggle mode, each `timeout` pulse inverts `pwm_out` on the next cycle. The first active phase starts from the idle level.
- R9: A cycle in which `mode_match` or `idle_high` differs from its value in the previous cycle drives `pwm_out` to the new idle level on the next cycle. This overrides any match or timeout in that cycle.
- R10: `pwm_out` is a register output. It changes only on the clock edge after the input event that causes the change, and it holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_value | input | CNT_W | Current timer counter value |
| timeout | input | 1 | One-cycle timeout strobe from the timer |
| match_val | input | CNT_W | Counter value that starts the active phase in match mode |
| mode_match | input | 1 | 0 = toggle mode, 1 = match mode |
| idle_high | input | 1 | 0 = idle low, 1 = idle high |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds the block with `CNT_W` = 4. This lets it sweep all sixteen match values against full up-count and down-count periods for every combination of mode and idle level. Because of that sweep, every match position is reached, including matches that coincide with the timeout at either end of the count and matches in the middle. A short-period run with a match value above the top of the count checks the case where the match is never reached. A pseudo-random segment then mixes counter values, timeout strobes and configuration flips, so that configuration changes land on match and timeout cycles as well.

// File: rtl/pwm_out_pkg.sv
// Shared types for the PWM output stage.
package pwm_out_pkg;
    // Operating mode, encoded as the mode-select input bit.
    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_MATCH  = 1'b1
    } pwm_mode_e;
endpackage

// File: rtl/pwm_hit_detect.sv
// Match comparator.
// Flags a cycle in which the counter equals the programmed match value.
// Assumes both operands are in the same (timer) clock domain.
module pwm_hit_detect #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_value,
    input  logic [CNT_W-1:0] match_val,
    output logic             hit
);
    // Equality compare of counter against match value.
    always_comb begin
        hit = (cnt_value == match_val);
    end
endmodule

// File: rtl/pwm_cfg_track.sv
// Configuration tracker.
// Keeps last-cycle copies of the mode and idle selections and flags any change.
// Assumes the selections are already synchronous to the timer clock.
module pwm_cfg_track
    import pwm_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwm_mode_e mode_in,
    input  logic      idle_in,
    output logic      idle_q,
    output logic      cfg_chg
);
    pwm_mode_e mode_q;

    // Capture the selections every cycle; reset to toggle mode, idle low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TOGGLE;
            idle_q <= 1'b0;
        end else begin
            mode_q <= mode_in;
            idle_q <= idle_in;
        end
    end

    // Report a difference between the current and the stored selections.
    always_comb begin
        cfg_chg = (mode_in != mode_q) || (idle_in != idle_q);
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MODE_TOGGLE && idle_q == 1'b0));
endmodule

// File: rtl/pwm_phase_ctl.sv
// Phase controller.
// Holds the active/idle phase and drives the registered output pin.
// Assumes timeout is a one-cycle strobe and hit is the current-cycle compare.
module pwm_phase_ctl
    import pwm_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwm_mode_e mode,
    input  logic      idle_in,
    input  logic      idle_q,
    input  logic      cfg_chg,
    input  logic      timeout,
    input  logic      hit,
    output logic      pwm_q
);
    logic active_q;
    logic active_d;

    // Next phase: a config change wins, then the mode's rules; timeout beats match.
    always_comb begin
        active_d = active_q;
        if (cfg_chg) begin
            active_d = 1'b0;
        end else if (mode == MODE_MATCH) begin
            if (timeout) begin
                active_d = 1'b0;
            end else if (hit) begin
                active_d = 1'b1;
            end
        end else if (timeout) begin
            active_d = ~active_q;
        end
    end

    // Register the phase and the pin; the active level is the inverse of idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pwm_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            pwm_q    <= idle_in ^ active_d;
        end
    end

    // R1
    out_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (pwm_q == 1'b0));
    // R4
    match_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && mode == MODE_MATCH && hit && !timeout) |=> (pwm_q != idle_q));
    // R5 R6
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && mode == MODE_MATCH && timeout) |=> (pwm_q == idle_q));
    // R8
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && mode == MODE_TOGGLE && timeout) |=> (pwm_q != $past(pwm_q)));
    // R9
    cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (pwm_q == idle_q));
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chg && !timeout && !(mode == MODE_MATCH && hit)) |=> $stable(pwm_q));
endmodule

// File: rtl/pwm_match_out.sv
// PWM output stage, top level.
// Drives one PWM pin from timer counter and timeout, in toggle or match mode.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module pwm_match_out
    import pwm_out_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             timeout,
    input  logic [CNT_W-1:0] match_val,
    input  logic             mode_match,
    input  logic             idle_high,
    output logic             pwm_out
);
    pwm_mode_e mode_sel;
    logic      hit;
    logic      idle_q;
    logic      cfg_chg;

    // Map the mode bit onto the mode type.
    always_comb begin
        mode_sel = pwm_mode_e'(mode_match);
    end

    pwm_hit_detect #(.CNT_W(CNT_W)) u_hit (
        .cnt_value (cnt_value),
        .match_val (match_val),
        .hit       (hit)
    );

    pwm_cfg_track u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_sel),
        .idle_in (idle_high),
        .idle_q  (idle_q),
        .cfg_chg (cfg_chg)
    );

    pwm_phase_ctl u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_sel),
        .idle_in (idle_high),
        .idle_q  (idle_q),
        .cfg_chg (cfg_chg),
        .timeout (timeout),
        .hit     (hit),
        .pwm_q   (pwm_out)
    );
endmodule

// File: tb/sim_pwm_match_out.sv
`timescale 1ns/1ps
module sim_pwm_match_out;
    localparam int W   = 4;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_value = '0;
    logic         timeout = 1'b0;
    logic [W-1:0] match_val = '0;
    logic         mode_match = 1'b0;
    logic         idle_high = 1'b0;
    logic         pwm_out;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;
    // Reference state from the requirements.
    logic m_act = 1'b0;
    logic m_mode = 1'b0;
    logic m_idle = 1'b0;
    logic m_exp = 1'b0;

    always #4 clk = ~clk;

    pwm_match_out #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .timeout(timeout),
        .match_val(match_val), .mode_match(mode_match), .idle_high(idle_high),
        .pwm_out(pwm_out)
    );

    task automatic check(input logic exp, input string tag);
        n_vec++;
        if (pwm_out !== exp) begin
            n_bad++;
            $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, pwm_out, exp, $time);
        end
    endtask

    // One cycle: drive inputs, update the model at the edge, check at the next falling edge.
    task automatic step(input logic [W-1:0] c, input logic t, input logic [W-1:0] m,
                        input logic md, input logic id, input string force_tag);
        logic  chg;
        string tag;
        cnt_value = c; timeout = t; match_val = m; mode_match = md; idle_high = id;
        @(posedge clk);
        chg = (md != m_mode) || (id != m_idle);
        if (chg)             tag = "R9";
        else if (md && t && c == m) tag = "R6";
        else if (md && t)    tag = "R5";
        else if (md && c == m) tag = "R4";
        else if (!md && t)   tag = "R8";
        else                 tag = "R10";
        if (chg) m_act = 1'b0;
        else if (md) begin
            if (t) m_act = 1'b0;
            else if (c == m) m_act = 1'b1;
        end else if (t) m_act = ~m_act;
        m_mode = md; m_idle = id;
        // R2 R3: expected level is idle inverted while active.
        m_exp = id ^ m_act;
        @(negedge clk);
        if (force_tag != "") tag = force_tag;
        check(m_exp, {tag, " R2 R3"});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL R10: watchdog expired, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic        md_r;
        logic        id_r;
        // R1: output low in reset and on the first cycle after.
        repeat (3) begin
            @(negedge clk);
            check(1'b0, "R1");
        end
        rst_n = 1'b1;
        step('0, 1'b0, '0, 1'b0, 1'b0, "R1");

        // Sweep idle level, mode, match value and count direction.
        for (int id = 0; id < 2; id++) begin
            for (int md = 0; md < 2; md++) begin
                for (int m = 0; m <= TOP; m++) begin
                    for (int dir = 0; dir < 2; dir++) begin
                        for (int p = 0; p < 2; p++) begin
                            for (int k = 0; k <= TOP; k++) begin
                                logic [W-1:0] c;
                                logic         t;
                                c = (dir == 0) ? W'(k) : W'(TOP - k);
                                t = (dir == 0) ? (k == TOP) : (k == TOP);
                                step(c, t, W'(m), md[0], id[0], "");
                            end
                        end
                    end
                end
            end
        end

        // R7: counter wraps at 7 and never reaches the match value 12.
        for (int id = 0; id < 2; id++) begin
            step('0, 1'b0, W'(12), 1'b1, id[0], "");
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 8; k++) begin
                    step(W'(k), k == 7, W'(12), 1'b1, id[0], "R7");
                end
            end
        end

        // Mixed pseudo-random stimulus with occasional configuration flips.
        lfsr = 16'hACE1;
        md_r = 1'b1; id_r = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:12] == 4'h3) md_r = ~md_r;
            if (lfsr[11:8] == 4'h5)  id_r = ~id_r;
            step(lfsr[3:0], lfsr[7:5] == 3'b101, lfsr[9] ? 4'h6 : 4'h9, md_r, id_r, "");
        end

        // R1: reset again from an arbitrary state.
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, "R1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule